// File: doc/BRIEF.md
# Control-Steered Two-Way Token Switch

This block steers a stream of data tokens to one of two destinations, one token at a time, under the direction of a separate control stream. It behaves as a small mode machine. In its control mode it accepts exactly one control token and decodes it into a routing decision. It then enters one of two data modes, moves exactly one data token to the chosen destination, and goes back to the control mode. It never takes a control token and a data token in the same cycle. So over each two-firing round the control port is consumed once and then the data port once.

All three streams (control in, data in, and the two data outputs called "true" and "false") use valid/ready handshaking. A transfer happens on a rising edge where valid and ready are both high. Back-pressure rules:
- In a data mode, the data input's ready is the selected output's ready, and the selected output's valid is the data input's valid. This is a combinational path with no extra latency.
- The unselected output's ready is ignored.
- A stall on either side holds the block in its current mode indefinitely.
- The only storage is the mode register, which holds the decoded control token.

Top module: `dflow_switch`

## Requirements
- R1: After reset the block is in control mode: `ctl_ready` is 1, `din_ready` is 0, and both `t_valid` and `f_valid` are 0.
- R2: While in control mode, `din_ready`, `t_valid` and `f_valid` stay 0 whatever `din_valid` does. No data token is consumed.
- R3: A control token whose value is nonzero, accepted at an edge, puts the block in true mode from the next cycle on. In true mode `t_valid` equals `din_valid` and `t_data` equals `din_data`.
- R4: A control token whose value is zero, accepted at an edge, puts the block in false mode from the next cycle on. In false mode `f_valid` equals `din_valid` and `f_data` equals `din_data`.
- R5: In either data mode `ctl_ready` is 0, so no control token is consumed even if `ctl_valid` is high.
- R6: In a data mode `din_ready` equals the selected output's ready. Without a data handshake the block stays in that data mode on the next cycle.
- R7: The unselected output never asserts valid. `t_valid` and `f_valid` are never high together.
- R8: The cycle after a data handshake, the block is back in control mode (`ctl_ready` is 1 and both outputs are idle).
- R9: In control mode without a control handshake, the block stays in control mode on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Control token offered |
| ctl_ready | output | 1 | Control token accepted (control mode only) |
| ctl_data | input | CTRL_W | Control value; nonzero selects true |
| din_valid | input | 1 | Data token offered |
| din_ready | output | 1 | Data token accepted |
| din_data | input | DATA_W | Data token |
| t_valid | output | 1 | True output valid |
| t_ready | input | 1 | True output ready |
| t_data | output | DATA_W | True output data |
| f_valid | output | 1 | False output valid |
| f_ready | input | 1 | False output ready |
| f_data | output | DATA_W | False output data |

## Verification
The hardest situation to reach is a data mode held over several cycles. In that state the data input and the selected output both stall, while the control input keeps offering a token and the unselected output is ready. A wrong design could then leak a control token, consume the data token, or raise the wrong valid. The stimulus sweeps every control value of a 2-bit control word. For each value it crosses separate delays before the data becomes valid and before the selected output becomes ready. During the whole wait it holds `ctl_valid` high and keeps the unselected ready high. Between tokens it also waits in control mode with `din_valid` already high, to show that data is not taken early.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    MODE_CTRL  = 2'd0,
    MODE_TRUE  = 2'd1,
    MODE_FALSE = 2'd2
  } dsw_mode_e;

  localparam int unsigned NUM_OUTS = 2;
endpackage

// File: rtl/dsw_enable.sv
// Enable logic: checks the token requirements of the current mode and
// produces ready signals and firing strobes.
module dsw_enable
  import dsw_pkg::*;
#(
  parameter int unsigned CTRL_W = 2
) (
  input  dsw_mode_e          mode,
  input  logic               ctl_valid,
  input  logic [CTRL_W-1:0]  ctl_data,
  input  logic               din_valid,
  input  logic               t_ready,
  input  logic               f_ready,
  output logic               ctl_ready,
  output logic               din_ready,
  output logic               ctl_fire,
  output logic               data_fire,
  output logic               sel_true
);
  always_comb begin
    ctl_ready = 1'b0;
    din_ready = 1'b0;
    unique case (mode)
      MODE_CTRL:  ctl_ready = 1'b1;
      MODE_TRUE:  din_ready = t_ready;
      MODE_FALSE: din_ready = f_ready;
      default:    ctl_ready = 1'b0;
    endcase
  end

  assign ctl_fire  = ctl_valid & ctl_ready;
  assign data_fire = din_valid & din_ready;
  assign sel_true  = |ctl_data;
endmodule

// File: rtl/dsw_mode_fsm.sv
// Mode register: holds the decoded control token between firings.
module dsw_mode_fsm
  import dsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_fire,
  input  logic      sel_true,
  input  logic      data_fire,
  output dsw_mode_e mode
);
  dsw_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_CTRL:  if (ctl_fire) mode_d = sel_true ? MODE_TRUE : MODE_FALSE;
      MODE_TRUE,
      MODE_FALSE: if (data_fire) mode_d = MODE_CTRL;
      default:    mode_d = MODE_CTRL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_CTRL;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/dsw_route.sv
// Output steering: one lane per destination, each active only in its mode.
module dsw_route
  import dsw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  dsw_mode_e                 mode,
  input  logic                      din_valid,
  input  logic [DATA_W-1:0]         din_data,
  output logic [NUM_OUTS-1:0]       out_valid,
  output logic [DATA_W-1:0]         out_data [NUM_OUTS]
);
  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_lane
    localparam dsw_mode_e LANE_MODE = (g == 0) ? MODE_TRUE : MODE_FALSE;
    assign out_valid[g] = din_valid & (mode == LANE_MODE);
    assign out_data[g]  = din_data;
  end
endmodule

// File: rtl/dflow_switch.sv
module dflow_switch
  import dsw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic [CTRL_W-1:0] ctl_data,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [DATA_W-1:0] din_data,
  output logic              t_valid,
  input  logic              t_ready,
  output logic [DATA_W-1:0] t_data,
  output logic              f_valid,
  input  logic              f_ready,
  output logic [DATA_W-1:0] f_data
);
  dsw_mode_e            mode;
  logic                 ctl_fire, data_fire, sel_true;
  logic [NUM_OUTS-1:0]  lane_valid;
  logic [DATA_W-1:0]    lane_data [NUM_OUTS];

  dsw_enable #(.CTRL_W(CTRL_W)) u_enable (
    .mode      (mode),
    .ctl_valid (ctl_valid),
    .ctl_data  (ctl_data),
    .din_valid (din_valid),
    .t_ready   (t_ready),
    .f_ready   (f_ready),
    .ctl_ready (ctl_ready),
    .din_ready (din_ready),
    .ctl_fire  (ctl_fire),
    .data_fire (data_fire),
    .sel_true  (sel_true)
  );

  dsw_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_fire  (ctl_fire),
    .sel_true  (sel_true),
    .data_fire (data_fire),
    .mode      (mode)
  );

  dsw_route #(.DATA_W(DATA_W)) u_route (
    .mode      (mode),
    .din_valid (din_valid),
    .din_data  (din_data),
    .out_valid (lane_valid),
    .out_data  (lane_data)
  );

  assign t_valid = lane_valid[0];
  assign t_data  = lane_data[0];
  assign f_valid = lane_valid[1];
  assign f_data  = lane_data[1];
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_valid,
  input logic              ctl_ready,
  input logic [CTRL_W-1:0] ctl_data,
  input logic              din_valid,
  input logic              din_ready,
  input logic              t_valid,
  input logic              f_valid
);
  // R7
  a_r7_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(t_valid && f_valid));
  // R2
  a_r2_ctrl_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ready |-> (!din_ready && !t_valid && !f_valid));
  // R3
  a_r3_to_true: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && (ctl_data != '0)) |=> (!ctl_ready && !f_valid));
  // R4
  a_r4_to_false: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && (ctl_data == '0)) |=> (!ctl_ready && !t_valid));
  // R6
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_ready && !(din_valid && din_ready)) |=> !ctl_ready);
  // R8
  a_r8_back_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> ctl_ready);
  // R9
  a_r9_hold_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ready && !ctl_valid) |=> ctl_ready);
endmodule

bind dflow_switch dsw_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dsw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_valid (ctl_valid),
  .ctl_ready (ctl_ready),
  .ctl_data  (ctl_data),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .t_valid   (t_valid),
  .f_valid   (f_valid)
);

// File: tb/test_dflow_switch.sv
`timescale 1ns/1ps
module test_dflow_switch;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_valid = 1'b0, ctl_ready;
  logic [CTRL_W-1:0] ctl_data = '0;
  logic din_valid = 1'b0, din_ready;
  logic [DATA_W-1:0] din_data = '0;
  logic t_valid, t_ready = 1'b0, f_valid, f_ready = 1'b0;
  logic [DATA_W-1:0] t_data, f_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dflow_switch #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_dflow_switch (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .t_valid(t_valid), .t_ready(t_ready), .t_data(t_data),
    .f_valid(f_valid), .f_ready(f_ready), .f_data(f_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_ctrl_mode(input string req);
    chk(req, "ctl_ready", int'(ctl_ready), 1);
    chk(req, "din_ready", int'(din_ready), 0);
    chk(req, "t_valid", int'(t_valid), 0);
    chk(req, "f_valid", int'(f_valid), 0);
  endtask

  // One round: idle in control mode, send control, then stalled data phase.
  task automatic one_round(input int cval, input int vdel, input int rdel, input int dval);
    bit sel = (cval != 0);
    bit done;
    // idle in control mode with data already offered (R2, R9)
    din_valid = 1'b1;
    din_data  = dval[DATA_W-1:0];
    ctl_valid = 1'b0;
    #1;
    check_ctrl_mode("R2");
    @(negedge clk);
    #1;
    check_ctrl_mode("R9");
    // offer control
    ctl_valid = 1'b1;
    ctl_data  = cval[CTRL_W-1:0];
    din_valid = 1'b0;
    @(negedge clk);
    // keep ctl_valid high through the data phase: must not be consumed (R5)
    ctl_data = ~cval[CTRL_W-1:0];
    done = 1'b0;
    for (int k = 0; !done; k++) begin
      din_valid = (k >= vdel);
      if (sel) begin t_ready = (k >= rdel); f_ready = 1'b1; end
      else     begin f_ready = (k >= rdel); t_ready = 1'b1; end
      #1;
      chk("R5", "ctl_ready in data mode", int'(ctl_ready), 0);
      if (sel) begin
        chk("R3", "t_valid", int'(t_valid), int'(din_valid));
        chk("R3", "t_data", int'(t_data), dval);
        chk("R7", "f_valid", int'(f_valid), 0);
        chk("R6", "din_ready", int'(din_ready), int'(t_ready));
      end else begin
        chk("R4", "f_valid", int'(f_valid), int'(din_valid));
        chk("R4", "f_data", int'(f_data), dval);
        chk("R7", "t_valid", int'(t_valid), 0);
        chk("R6", "din_ready", int'(din_ready), int'(f_ready));
      end
      done = (k >= vdel) && (k >= rdel);
      @(negedge clk);
    end
    ctl_valid = 1'b0;
    din_valid = 1'b0;
    t_ready = 1'b0;
    f_ready = 1'b0;
    #1;
    check_ctrl_mode("R8");
  endtask

  initial begin
    #1;
    check_ctrl_mode("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_ctrl_mode("R1");
    for (int c = 0; c < (1 << CTRL_W); c++)
      for (int v = 0; v < 3; v++)
        for (int r = 0; r < 3; r++)
          one_round(c, v, r, (c * 37 + v * 11 + r * 5 + 1) & 8'hFF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule